// File: doc/BRIEF.md
# Two-Level Speculative Parallel Decision-Feedback Equalizer

This block turns a frame of up to 17 interpolated, signed receiver samples per clock into binary decisions, cancelling the post-cursor interference of the two preceding bits with a two-tap decision-feedback equalizer. The tap weights are set from outside and are never adapted. Each lane compares its sample against all four possible feedback values at once. No adder therefore sits in the serial decision path, which only steers precomputed candidates through multiplexers.

The lanes are split into groups of eight. Every group resolves its multiplexer chain once for each of the four possible incoming bit pairs. A short group-level selection then links the groups in order, starting from the pair of bits carried over from the previous frame. A lane mask marks which lanes hold real samples, so that frequency offset can be absorbed with 15, 16 or 17 bits per frame. Decisions, a count of valid bits and the carried bit pair appear three clock edges after a frame is presented.

Top module: `spec_dfe_top`

## Requirements
- R1: A valid lane decides 1 when its sample minus the feedback is greater than or equal to zero, and 0 otherwise. The feedback is h1·s1 + h2·s2, where s1 and s2 are the two most recent earlier valid decisions, each mapped to +1 for bit 1 and −1 for bit 0.
- R2: Decisions chain across lanes in ascending lane order, and from the highest valid lane of one frame into lane 0 of the next frame.
- R3: A lane whose mask bit is 0 outputs decision 0 and does not advance the decision history.
- R4: `dec_cnt` equals the number of set bits in the mask of the frame that `dec_out` belongs to.
- R5: `last_pair[1]` holds the most recent valid decision and `last_pair[0]` the one before it, both taken from the highest valid lanes seen so far.
- R6: A frame presented before rising edge t appears on the outputs after rising edge t+2.
- R7: A frame with an all-zero mask outputs zero decisions and a count of zero, and leaves the carried history unchanged.
- R8: Synchronous reset clears all outputs and sets the carried history to bit pair 00.
- R9: Frames of 15, 16 and 17 contiguous low lanes are accepted on consecutive clocks with no gap.
- R10: The taps are sampled together with each frame, so a tap change applies from the frame presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | NL*SW | Signed samples, lane l in bits [l*SW +: SW] |
| lane_vld | input | NL | Lane mask, bit l marks lane l valid |
| tap_a | input | TW | Signed first-tap weight h1 |
| tap_b | input | TW | Signed second-tap weight h2 |
| dec_out | output | NL | Decided bits, bit l for lane l |
| dec_cnt | output | $clog2(NL+1) | Number of valid bits in dec_out |
| last_pair | output | 2 | Carried history: [1] newest, [0] older |

## Verification
The bench targets the carry across frame and group boundaries. A wrong group selection or frame carry flips whole groups of bits once the taps are large. Frames of 15 and 16 lanes show whether the history is taken from the top valid lane or from lane 16. A block that took it from lane 16 would feed stale bits into the next frame. Sparse masks and empty frames test that invalid lanes neither emit ones nor shift the history. Zero samples with zero taps hit the equal-to-zero slicing boundary. Per-frame tap changes expose a design that applies the taps one frame early or late.

// File: rtl/spec_dfe_pkg.sv
package spec_dfe_pkg;
  // decision history: [1] newest bit, [0] older bit
  typedef logic [1:0] hist_t;

  function automatic hist_t push_hist(hist_t h, logic b);
    return {b, h[1]};
  endfunction
endpackage

// File: rtl/dfe_lane_slicer.sv
module dfe_lane_slicer #(
  parameter int SW = 6,
  parameter int TW = 6
) (
  input  logic signed [SW-1:0] smp,
  input  logic signed [TW-1:0] t1,
  input  logic signed [TW-1:0] t2,
  output logic        [3:0]    dec
);
  localparam int DW = ((SW > TW) ? SW : TW) + 2;

  // candidate index k: k[1] = newest earlier bit, k[0] = older bit
  for (genvar k = 0; k < 4; k++) begin : g_hyp
    logic signed [DW-1:0] fb;
    logic signed [DW-1:0] diff;
    always_comb begin
      fb   = ((k & 2) != 0 ? DW'(t1) : -DW'(t1))
           + ((k & 1) != 0 ? DW'(t2) : -DW'(t2));
      diff = DW'(smp) - fb;
      dec[k] = ~diff[DW-1];
    end
  end
endmodule

// File: rtl/dfe_group_chain.sv
module dfe_group_chain
  import spec_dfe_pkg::*;
#(
  parameter int GL = 8
) (
  input  logic [GL-1:0][3:0] cand,
  input  logic [GL-1:0]      vmask,
  input  hist_t              start,
  output logic [GL-1:0]      bits,
  output hist_t              fin
);
  hist_t p;
  always_comb begin
    p = start;
    for (int i = 0; i < GL; i++) begin
      bits[i] = 1'b0;
      if (vmask[i]) begin
        bits[i] = cand[i][p];
        p = push_hist(p, cand[i][p]);
      end
    end
    fin = p;
  end
endmodule

// File: rtl/dfe_group_select.sv
module dfe_group_select
  import spec_dfe_pkg::*;
#(
  parameter int NG = 3,
  parameter int GL = 8
) (
  input  logic  [NG-1:0][3:0][GL-1:0] sb,
  input  logic  [NG-1:0][3:0][1:0]    sf,
  input  hist_t                       carry,
  output logic  [NG*GL-1:0]           bits,
  output hist_t                       nxt
);
  hist_t c;
  always_comb begin
    c = carry;
    for (int g = 0; g < NG; g++) begin
      bits[g*GL +: GL] = sb[g][c];
      c = sf[g][c];
    end
    nxt = c;
  end
endmodule

// File: rtl/spec_dfe_top.sv
module spec_dfe_top
  import spec_dfe_pkg::*;
#(
  parameter int NL  = 17,
  parameter int GRP = 8,
  parameter int SW  = 6,
  parameter int TW  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NL*SW-1:0]           smp_in,
  input  logic [NL-1:0]              lane_vld,
  input  logic [TW-1:0]              tap_a,
  input  logic [TW-1:0]              tap_b,
  output logic [NL-1:0]              dec_out,
  output logic [$clog2(NL+1)-1:0]    dec_cnt,
  output logic [1:0]                 last_pair
);
  localparam int NG  = (NL + GRP - 1) / GRP;
  localparam int NLP = NG * GRP;
  localparam int CW  = $clog2(NL + 1);

  // stage 1: four-way speculative slicing per lane
  logic [NLP-1:0][3:0] cand_c, cand_q;
  logic [NLP-1:0]      msk_c, msk1_q, msk2_q;

  for (genvar l = 0; l < NLP; l++) begin : g_lane
    if (l < NL) begin : g_real
      dfe_lane_slicer #(.SW(SW), .TW(TW)) u_slc (
        .smp (smp_in[l*SW +: SW]),
        .t1  (tap_a),
        .t2  (tap_b),
        .dec (cand_c[l])
      );
      assign msk_c[l] = lane_vld[l];
    end else begin : g_pad
      assign cand_c[l] = '0;
      assign msk_c[l]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      msk1_q <= '0;
    end else begin
      cand_q <= cand_c;
      msk1_q <= msk_c;
    end
  end

  // stage 2: each group resolved for all four incoming histories
  logic [NG-1:0][3:0][GRP-1:0] sb_c, sb_q;
  logic [NG-1:0][3:0][1:0]     sf_c, sf_q;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar h = 0; h < 4; h++) begin : g_hist
      dfe_group_chain #(.GL(GRP)) u_chain (
        .cand  (cand_q[g*GRP +: GRP]),
        .vmask (msk1_q[g*GRP +: GRP]),
        .start (2'(h)),
        .bits  (sb_c[g][h]),
        .fin   (sf_c[g][h])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_q   <= '0;
      sf_q   <= '0;
      msk2_q <= '0;
    end else begin
      sb_q   <= sb_c;
      sf_q   <= sf_c;
      msk2_q <= msk1_q;
    end
  end

  // stage 3: link groups from the carried history
  hist_t            carry_q, carry_c;
  logic [NLP-1:0]   sel_bits;

  dfe_group_select #(.NG(NG), .GL(GRP)) u_sel (
    .sb    (sb_q),
    .sf    (sf_q),
    .carry (carry_q),
    .bits  (sel_bits),
    .nxt   (carry_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_out <= '0;
      dec_cnt <= '0;
      carry_q <= 2'b00;
    end else begin
      dec_out <= sel_bits[NL-1:0];
      dec_cnt <= CW'($countones(msk2_q));
      carry_q <= carry_c;
    end
  end

  assign last_pair = carry_q;

  // ---------------- assertions ----------------
  if (NLP > NL) begin : g_padchk
    always_comb begin
      // R3
      pad_lane_zero_chk: assert (sel_bits[NLP-1:NL] == '0);
    end
  end

  // R3
  inv_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_out & ~$past(msk2_q[NL-1:0])) == '0);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_cnt <= CW'(NL)) && ($countones(dec_out) <= int'(dec_cnt)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msk2_q == '0) |=> ($stable(carry_q) && dec_cnt == '0));

  // R2
  empty_group_chk: assert property (@(posedge clk) disable iff (rst)
    (msk1_q[GRP-1:0] == '0) |=>
      (sf_q[0][0] == 2'd0 && sf_q[0][1] == 2'd1 &&
       sf_q[0][2] == 2'd2 && sf_q[0][3] == 2'd3));
endmodule

// File: tb/tb_spec_dfe_top.sv
`timescale 1ns/1ps
module tb_spec_dfe_top;
  localparam int NL = 17;
  localparam int SW = 6;
  localparam int TW = 6;
  localparam int CW = $clog2(NL + 1);
  localparam int NC = 210;
  localparam int MAXC = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL*SW-1:0] smp_in = '0;
  logic [NL-1:0]    lane_vld = '0;
  logic [TW-1:0]    tap_a = '0;
  logic [TW-1:0]    tap_b = '0;
  logic [NL-1:0]    dec_out;
  logic [CW-1:0]    dec_cnt;
  logic [1:0]       last_pair;

  always #2.5 clk = ~clk;

  spec_dfe_top #(.NL(NL), .GRP(8), .SW(SW), .TW(TW)) dut (
    .clk(clk), .rst(rst), .smp_in(smp_in), .lane_vld(lane_vld),
    .tap_a(tap_a), .tap_b(tap_b),
    .dec_out(dec_out), .dec_cnt(dec_cnt), .last_pair(last_pair)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NL-1:0] e_bits [MAXC];
  int            e_cnt  [MAXC];
  logic [1:0]    e_pair [MAXC];
  string         e_tag  [MAXC];

  int xs [NL];
  int ta, tb;
  int hc1 = 0, hc2 = 0;   // reference history: hc1 newest

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  // serial reference DFE over one frame
  task automatic ref_frame(input logic [NL-1:0] m, input int slot, input string tag);
    logic [NL-1:0] b = '0;
    int fb;
    for (int l = 0; l < NL; l++) begin
      if (m[l]) begin
        fb = (hc1 != 0 ? ta : -ta) + (hc2 != 0 ? tb : -tb);
        b[l] = (xs[l] - fb) >= 0;
        hc2 = hc1;
        hc1 = b[l];
      end
    end
    e_bits[slot] = b;
    e_cnt[slot]  = $countones(m);
    e_pair[slot] = {hc1[0], hc2[0]};
    e_tag[slot]  = tag;
  endtask

  function automatic int rnd_s(input int w);
    logic [31:0] r = $urandom;
    return (int'(r % (1 << w))) - (1 << (w - 1));
  endfunction

  initial begin
    int k;
    logic [NL-1:0] m;
    string tag;
    repeat (4) @(negedge clk);
    // R8: outputs cleared, history 00 under reset
    chk("R8", "dec_out", int'(dec_out), 0);
    chk("R8", "dec_cnt", int'(dec_cnt), 0);
    chk("R8", "last_pair", int'(last_pair), 0);
    rst = 1'b0;
    for (k = 0; k < NC + 3; k++) begin
      if (k >= 3) begin
        // R6: frame k-3 observed after its third capturing edge
        chk(e_tag[k-3], "dec_out R1/R6", int'(dec_out), int'(e_bits[k-3]));
        chk(e_tag[k-3], "dec_cnt R4", int'(dec_cnt), e_cnt[k-3]);
        chk(e_tag[k-3], "last_pair R5", int'(last_pair), int'(e_pair[k-3]));
      end
      ta = 11; tb = -5;
      for (int l = 0; l < NL; l++) xs[l] = rnd_s(SW);
      if (k < 40) begin
        m = '1; tag = "R1 R2 R9 full";
      end else if (k < 80) begin
        m = (k % 2 == 0) ? 17'h0FFFF : 17'h07FFF; tag = "R5 R9 15/16";
      end else if (k < 120) begin
        m = (k % 3 == 0) ? '0 : 17'h0FFFF; tag = "R7 idle";
      end else if (k < 160) begin
        m = NL'($urandom); tag = "R3 R4 sparse";
      end else if (k < 170) begin
        ta = 0; tb = 0; m = '1; tag = "R1 zero boundary";
        for (int l = 0; l < NL; l++) xs[l] = (l % 3 == 0) ? -1 : 0;
      end else if (k < NC) begin
        ta = rnd_s(TW); tb = rnd_s(TW); m = '1; tag = "R10 taps";
      end else begin
        m = '0; tag = "R7 flush";
      end
      ref_frame(m, k, tag);
      for (int l = 0; l < NL; l++) smp_in[l*SW +: SW] = SW'(xs[l]);
      lane_vld = m;
      tap_a = TW'(ta);
      tap_b = TW'(tb);
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R6 got hang exp finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule